// File: doc/BRIEF.md
# PLL Lock Qualifier with Sticky Loss Flags

This block watches the raw lock indications of three PLLs: main at bit 0, peripheral at bit 1 and memory at bit 2. Each raw indication is asynchronous to the block clock, so it first passes through a synchroniser. On every cycle in which the sample strobe is high, the qualifier checks the synchronised lock bits that the lock mask selects. It declares the system locked only after a run of consecutive samples in which every selected PLL reports lock. Any sample with a selected PLL out of lock ends the run, and the locked indication then drops at once.

The qualifier is a three-state machine:

- `QS_HUNT`: no run is in progress and the counter is zero.
- `QS_RUN`: a run is in progress and being counted.
- `QS_HELD`: the run target has been met and the qualified flag is high.

Its transitions are:

- `HUNT->RUN`, on a good sample while the target is not yet met.
- `RUN->RUN`, on a good sample below the target.
- `HUNT/RUN->HELD`, on the good sample that reaches the target.
- `HUNT/RUN->HUNT`, on a bad sample.
- `HELD->HUNT`, on a bad sample.
- Every state holds when no sample is taken.

Alongside the qualifier, each PLL has a sticky loss flag. The flag is set when that PLL's synchronised lock falls. Software clears it by writing one to its bit.

Top module: `pll_lock_qualifier`

## Requirements
- R1: Each bit of `lock_sync_o` equals the matching bit of `lock_raw_i` delayed through two flip-flops on the block clock.
- R2: A sample is good only when every PLL whose `lock_mask_i` bit is 1 shows 1 on `lock_sync_o`. Unmasked PLLs are ignored. With an all-zero mask, every sample is good.
- R3: Each good sample (a cycle with `sample_i` high) adds one to the run count, which saturates at the target. Each bad sample returns the count to zero. Cycles with `sample_i` low leave the count unchanged.
- R4: `locked_o` rises in the cycle after the clock edge that takes the 10th consecutive good sample. After only 9 good samples it stays low.
- R5: `locked_o` falls in the cycle after the clock edge that takes a bad sample. It rises again only after a fresh run of 10 good samples.
- R6: `lost_o[i]` becomes 1 in the cycle after the edge at which bit i of `lock_sync_o` goes from 1 to 0. After that it stays 1 until it is cleared. Bit 0 is main, bit 1 is peripheral and bit 2 is memory.
- R7: On a cycle with `clr_we_i` high, each `clr_data_i` bit at 1 clears the matching `lost_o` bit. Each bit at 0 leaves its `lost_o` bit unchanged.
- R8: When a loss event and a clearing write fall on the same bit in the same cycle, the bit ends up set.
- R9: While reset is asserted and right after it, `locked_o`, `lock_sync_o`, `lost_o` and the run count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_raw_i | input | 3 | Asynchronous raw lock bits (0 main, 1 peripheral, 2 memory) |
| sample_i | input | 1 | Strobe that takes one qualifier sample |
| lock_mask_i | input | 3 | Selects which PLLs must be locked |
| clr_we_i | input | 1 | Write strobe for clearing loss flags |
| clr_data_i | input | 3 | Write-one-to-clear data for the loss flags |
| locked_o | output | 1 | Qualified all-locked flag |
| lock_sync_o | output | 3 | Synchronised lock bits |
| lost_o | output | 3 | Sticky loss-of-lock flags |

## Verification
The bench builds the block with its default values: three PLLs, a 10-sample run target and two synchroniser stages. With three PLLs, all eight mask combinations and every pattern of single and multiple lock drops can be reached in a short random phase. A 10-sample target keeps the 9-versus-10 boundary and reacquisition after a drop within a few dozen cycles. Random stimulus favours mostly-locked inputs, so that long runs occur often. Directed sequences place a clearing write on the exact edge of a loss event.

// File: rtl/pll_lq_pkg.sv
package pll_lq_pkg;

    typedef enum logic [1:0] {
        QS_HUNT = 2'd0,
        QS_RUN  = 2'd1,
        QS_HELD = 2'd2
    } qual_state_e;

endpackage

// File: rtl/pll_lq_sync.sv
module pll_lq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/pll_lq_run_fsm.sv
module pll_lq_run_fsm
    import pll_lq_pkg::*;
#(
    parameter int NUM_PLL    = 3,
    parameter int RUN_TARGET = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_i,
    input  logic [NUM_PLL-1:0] lock_i,
    input  logic [NUM_PLL-1:0] mask_i,
    output logic               locked_o
);
    localparam int CNT_W = $clog2(RUN_TARGET + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(RUN_TARGET - 1);
    localparam logic [CNT_W-1:0] FULL_RUN  = CNT_W'(RUN_TARGET);

    qual_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             all_ok;

    assign all_ok = ((lock_i & mask_i) == mask_i);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (sample_i) begin
            unique case (state_q)
                QS_HUNT, QS_RUN: begin
                    if (!all_ok) begin
                        state_d = QS_HUNT;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST_STEP) begin
                        state_d = QS_HELD;
                        cnt_d   = FULL_RUN;
                    end else begin
                        state_d = QS_RUN;
                        cnt_d   = cnt_q + CNT_W'(1);
                    end
                end
                QS_HELD: begin
                    if (!all_ok) begin
                        state_d = QS_HUNT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = QS_HUNT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QS_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        locked_o = (state_q == QS_HELD);
    end

    // R5
    drop_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !all_ok) |=> !locked_o);

    // R4
    rise_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(sample_i && all_ok));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_RUN);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(cnt_q));

    // R4
    held_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (cnt_q == FULL_RUN));

endmodule

// File: rtl/pll_lq_loss_bank.sv
module pll_lq_loss_bank #(
    parameter int NUM_PLL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PLL-1:0] lock_i,
    input  logic               clr_we_i,
    input  logic [NUM_PLL-1:0] clr_data_i,
    output logic [NUM_PLL-1:0] lost_o
);
    logic [NUM_PLL-1:0] prev_q;
    logic [NUM_PLL-1:0] lost_q;
    logic [NUM_PLL-1:0] fall_ev;
    logic [NUM_PLL-1:0] clr_req;

    assign fall_ev = prev_q & ~lock_i;
    assign clr_req = clr_we_i ? clr_data_i : '0;

    generate
        for (genvar i = 0; i < NUM_PLL; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q[i] <= 1'b0;
                    lost_q[i] <= 1'b0;
                end else begin
                    prev_q[i] <= lock_i[i];
                    if (fall_ev[i])      lost_q[i] <= 1'b1;
                    else if (clr_req[i]) lost_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    assign lost_o = lost_q;

    // R6 R8
    lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lost_o & $past(prev_q & ~lock_i)) == $past(prev_q & ~lock_i)));

    // R7
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((lost_o & $past(clr_data_i & ~(prev_q & ~lock_i))) == '0));

    // R7
    lost_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~lost_o & $past(lost_o & ~(clr_we_i ? clr_data_i : '0))) == '0));

endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier #(
    parameter int NUM_PLL     = 3,
    parameter int RUN_TARGET  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PLL-1:0] lock_raw_i,
    input  logic               sample_i,
    input  logic [NUM_PLL-1:0] lock_mask_i,
    input  logic               clr_we_i,
    input  logic [NUM_PLL-1:0] clr_data_i,
    output logic               locked_o,
    output logic [NUM_PLL-1:0] lock_sync_o,
    output logic [NUM_PLL-1:0] lost_o
);
    logic [NUM_PLL-1:0] lock_sync;

    pll_lq_sync #(
        .WIDTH  (NUM_PLL),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lock_raw_i),
        .sync_o  (lock_sync)
    );

    pll_lq_run_fsm #(
        .NUM_PLL    (NUM_PLL),
        .RUN_TARGET (RUN_TARGET)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .lock_i   (lock_sync),
        .mask_i   (lock_mask_i),
        .locked_o (locked_o)
    );

    pll_lq_loss_bank #(
        .NUM_PLL (NUM_PLL)
    ) u_loss (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (lock_sync),
        .clr_we_i   (clr_we_i),
        .clr_data_i (clr_data_i),
        .lost_o     (lost_o)
    );

    assign lock_sync_o = lock_sync;

    // R2
    lock_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && sample_i && ((lock_sync & lock_mask_i) != lock_mask_i)) |=> !locked_o);

endmodule

// File: tb/pll_lock_qualifier_test.sv
module pll_lock_qualifier_test;
    localparam int N      = 3;
    localparam int TARGET = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] lock_raw = '0;
    logic         sample = 1'b0;
    logic [N-1:0] mask = '1;
    logic         clr_we = 1'b0;
    logic [N-1:0] clr_data = '0;
    logic         locked;
    logic [N-1:0] lock_sync;
    logic [N-1:0] lost;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pll_lock_qualifier uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_raw_i  (lock_raw),
        .sample_i    (sample),
        .lock_mask_i (mask),
        .clr_we_i    (clr_we),
        .clr_data_i  (clr_data),
        .locked_o    (locked),
        .lock_sync_o (lock_sync),
        .lost_o      (lost)
    );

    // reference model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_prev, m_lost;
    int           m_cnt;
    logic         m_locked;

    function automatic logic good_sample(logic [N-1:0] l, logic [N-1:0] m);
        return ((l & m) == m);
    endfunction

    function automatic int next_cnt(int c, logic smp, logic ok);
        if (!smp) return c;
        if (!ok) return 0;
        return (c >= TARGET) ? TARGET : c + 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_lost <= '0;
            m_cnt <= 0; m_locked <= 1'b0;
        end else begin
            int nc;
            nc = next_cnt(m_cnt, sample, good_sample(m_s2, mask));
            m_cnt    <= nc;
            m_locked <= (nc >= TARGET);
            m_s1     <= lock_raw;
            m_s2     <= m_s1;
            m_prev   <= m_s2;
            m_lost   <= (m_lost & ~(clr_we ? clr_data : '0)) | (m_prev & ~m_s2);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(lock_sync == m_s2, "R1 sync", lock_sync, m_s2);
            chk(locked == m_locked, "R2 R3 R4 R5 locked", locked, m_locked);
            chk(lost == m_lost, "R6 R7 R8 lost", lost, m_lost);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        cyc(3);
        // R9 outputs held at zero during reset
        chk(locked == 1'b0, "R9 locked in reset", locked, 0);
        chk(lost == '0, "R9 lost in reset", lost, 0);
        chk(lock_sync == '0, "R9 sync in reset", lock_sync, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(locked == 1'b0 && lost == '0, "R9 after reset", {locked, lost}, 0);

        // R4: 9 good samples keep locked low, the 10th raises it
        lock_raw = 3'b111; mask = 3'b111;
        cyc(3);
        sample = 1'b1;
        cyc(TARGET - 1);
        chk(locked == 1'b0, "R4 nine samples", locked, 0);
        cyc(1);
        chk(locked == 1'b1, "R4 ten samples", locked, 1);

        // R5 R6: peripheral drops, lock falls and loss flag sets
        lock_raw = 3'b101;
        cyc(3);
        chk(locked == 1'b0, "R5 drop on miss", locked, 0);
        chk(lost == 3'b010, "R6 peripheral lost", lost, 3'b010);

        // R5: reacquire needs a fresh run
        lock_raw = 3'b111;
        cyc(2 + TARGET - 1);
        chk(locked == 1'b0, "R5 partial rerun", locked, 0);
        cyc(1);
        chk(locked == 1'b1, "R5 rerun complete", locked, 1);

        // R3: no sample keeps the count, a later drop still resets it
        sample = 1'b0;
        cyc(5);
        chk(locked == 1'b1, "R3 hold without sample", locked, 1);
        sample = 1'b1;

        // R7: writing zero to a bit keeps it, writing one clears it
        clr_we = 1'b1; clr_data = 3'b101;
        cyc(1);
        clr_we = 1'b0;
        chk(lost == 3'b010, "R7 write zero keeps", lost, 3'b010);
        clr_we = 1'b1; clr_data = 3'b010;
        cyc(1);
        clr_we = 1'b0;
        chk(lost == 3'b000, "R7 write one clears", lost, 0);

        // R8: memory PLL falls on the same edge as a clearing write
        lock_raw = 3'b011;
        cyc(2);
        clr_we = 1'b1; clr_data = 3'b100;
        cyc(1);
        clr_we = 1'b0;
        chk(lost == 3'b100, "R8 set beats clear", lost, 3'b100);

        // R2: only the main PLL selected
        mask = 3'b001; lock_raw = 3'b001;
        cyc(3 + TARGET);
        chk(locked == 1'b1, "R2 masked pll ignored", locked, 1);
        mask = 3'b000; lock_raw = 3'b000;
        cyc(3 + TARGET);
        chk(locked == 1'b1, "R2 empty mask", locked, 1);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (($urandom % 8) != 0) lock_raw = '1;
            else lock_raw = N'($urandom);
            sample = (($urandom % 4) != 0);
            if (($urandom % 64) == 0) mask = N'($urandom);
            clr_we = (($urandom % 6) == 0);
            clr_data = N'($urandom);
        end
        clr_we = 1'b0;
        cyc(4);
        finish_run();
    end

endmodule